// File: doc/BRIEF.md
# Broadcast Command and Address Mapper

This block sits between a serial host front end and a four-channel UART register file. Each accepted transaction carries a 5-bit host register address, a 2-bit channel select, a direction bit and a data byte. The block turns it into an 8-bit internal register address, a one-hot or all-ones set of channel enables, and single-cycle command strobes. All outputs are registered and appear in the cycle after the request is accepted.

Host address 0x1F is a shared command port. A write to that address goes to every channel at once, whatever the channel select says. Two command values turn a sticky page mode on and off. While the mode is on, the short host address selects a register in the upper page starting at internal address 0x20. This page holds the synchronization, delay, timer and revision registers. Command values 0xE0 to 0xEF raise a transmit-synchronization strobe, and its 4-bit index goes to all channels.

Top module: `bcast_cmd_mapper`

## Requirements
- R1: A write to host address 0x1F is a global command. One cycle later `global_o` is 1, `chan_en_o` is 4'b1111 whatever `req_chan_i` holds, and `map_addr_o` is 0x1F.
- R2: A global write with data 0xCE sets the page mode, and `ext_mode_o` reads 1 from the cycle after the write onward.
- R3: A global write with data 0xCD clears the page mode. `ext_mode_o` is 0 after reset.
- R4: In normal mode, a transaction that is not a global write maps to `map_addr_o` = {3'b000, host address}.
- R5: In page mode, a transaction that is not a global write maps to `map_addr_o` = {4'b0010, host address[3:0]}, and host address bit 4 has no effect. For example, host 0x00 gives 0x20, and both 0x05 and 0x15 give 0x25.
- R6: For every transaction that is not a global write, in either mode, `chan_en_o` is one-hot, and bit n is set when `req_chan_i` = n.
- R7: A global write with data 0xE0 to 0xEF raises `sync_stb_o` for exactly one cycle, in the cycle after the write, with `sync_idx_o` equal to the data's low nibble.
- R8: While page mode is on, a write to host address 0x1F is still the global port, so a 0xCD write always leaves page mode.
- R9: A global write with any other data value raises no strobe and leaves `ext_mode_o` unchanged.
- R10: A read never changes `ext_mode_o`, never raises `sync_stb_o`, and enables only the selected channel. A read of host 0x1F is mapped like any other address.
- R11: `map_valid_o` is 1 exactly in the cycle after an accepted request, with `map_data_o` and `map_write_o` copied from it. In idle cycles `chan_en_o` is 0 and `sync_stb_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Transaction accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Host register address |
| req_chan_i | input | 2 | Channel select |
| req_data_i | input | 8 | Write data byte |
| map_valid_o | output | 1 | Mapped transaction present |
| map_write_o | output | 1 | Direction of mapped transaction |
| map_addr_o | output | 8 | Internal register address |
| map_data_o | output | 8 | Data byte passed through |
| chan_en_o | output | 4 | Per-channel enables |
| global_o | output | 1 | Transaction is a global command write |
| ext_mode_o | output | 1 | Page mode flag |
| sync_stb_o | output | 1 | Transmit-sync command strobe |
| sync_idx_o | output | 4 | Transmit-sync command index |

## Verification
The address mapping is exercised with the same host addresses in both modes. Addresses with bit 4 set are included, so a mapper that ignores the mode, or that keeps bit 4 in page mode, gives the wrong result. Command bytes are written at 0x1F with several different channel selects, next to a read of 0x1F that carries 0xCD on the data bus. This separates broadcast writes from reads and shows that only writes change the mode. The command values tested are the two ends of the sync range, back-to-back sync commands, repeated set commands and values outside every recognised group, in both modes. This separates the strobe decode from the mode decode and shows that the mode flag is sticky.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  localparam int HOST_AW = 5;
  localparam int INT_AW  = 8;
  localparam int DW      = 8;
  localparam int NUM_CH  = 4;
  localparam int PAGE_W  = 4;

  localparam logic [HOST_AW-1:0] GLOBAL_ADDR = 5'h1F;
  localparam logic [DW-1:0]      CMD_EXT_ON  = 8'hCE;
  localparam logic [DW-1:0]      CMD_EXT_OFF = 8'hCD;
  localparam logic [3:0]         SYNC_GRP    = 4'hE;
  localparam logic [PAGE_W-1:0]  EXT_PAGE    = 4'h2;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_EXT_SET,
    CMD_EXT_CLR,
    CMD_SYNC
  } cmd_e;
endpackage

// File: rtl/bcm_addr_map.sv
module bcm_addr_map #(
  parameter int HOST_AW = 5,
  parameter int INT_AW  = 8,
  parameter int PAGE_W  = 4,
  parameter logic [PAGE_W-1:0] PAGE = 4'h2
) (
  input  logic [HOST_AW-1:0] addr_i,
  input  logic               ext_i,
  input  logic               global_i,
  output logic [INT_AW-1:0]  addr_o
);
  localparam int LOW_W = HOST_AW - 1;

  always_comb begin
    if (global_i || !ext_i) begin
      addr_o = INT_AW'(addr_i);
    end else begin
      // page base plus low bits; top host bit dropped
      addr_o = (INT_AW'(PAGE) << LOW_W) | INT_AW'(addr_i[LOW_W-1:0]);
    end
  end
endmodule

// File: rtl/bcm_cmd_decode.sv
module bcm_cmd_decode
  import bcm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data_i,
  output cmd_e          cmd_o,
  output logic [3:0]    idx_o
);
  always_comb begin
    idx_o = data_i[3:0];
    if (data_i == CMD_EXT_ON)          cmd_o = CMD_EXT_SET;
    else if (data_i == CMD_EXT_OFF)    cmd_o = CMD_EXT_CLR;
    else if (data_i[DW-1:DW-4] == SYNC_GRP) cmd_o = CMD_SYNC;
    else                               cmd_o = CMD_NONE;
  end
endmodule

// File: rtl/bcm_mode_reg.sv
module bcm_mode_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_o <= 1'b0;
    else if (set_i)  mode_o <= 1'b1;
    else if (clr_i)  mode_o <= 1'b0;
  end
endmodule

// File: rtl/bcm_chan_sel.sv
module bcm_chan_sel #(
  parameter int NUM_CH = 4,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              all_i,
  output logic [NUM_CH-1:0] en_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign en_o[g] = all_i || (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/bcast_cmd_mapper.sv
module bcast_cmd_mapper
  import bcm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [HOST_AW-1:0] req_addr_i,
  input  logic [$clog2(NUM_CH)-1:0] req_chan_i,
  input  logic [DW-1:0]      req_data_i,
  output logic               map_valid_o,
  output logic               map_write_o,
  output logic [INT_AW-1:0]  map_addr_o,
  output logic [DW-1:0]      map_data_o,
  output logic [NUM_CH-1:0]  chan_en_o,
  output logic               global_o,
  output logic               ext_mode_o,
  output logic               sync_stb_o,
  output logic [3:0]         sync_idx_o
);
  logic              gport_wr;
  logic              gcmd;
  cmd_e              cmd;
  logic [3:0]        idx;
  logic [INT_AW-1:0] addr_m;
  logic [NUM_CH-1:0] en_m;

  // port match uses the raw host address, so it holds in either mode
  assign gport_wr = req_write_i && (req_addr_i == GLOBAL_ADDR);
  assign gcmd     = req_valid_i && gport_wr;

  bcm_cmd_decode #(.DW(DW)) u_dec (
    .data_i (req_data_i),
    .cmd_o  (cmd),
    .idx_o  (idx)
  );

  bcm_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (gcmd && (cmd == CMD_EXT_SET)),
    .clr_i  (gcmd && (cmd == CMD_EXT_CLR)),
    .mode_o (ext_mode_o)
  );

  bcm_addr_map #(
    .HOST_AW (HOST_AW),
    .INT_AW  (INT_AW),
    .PAGE_W  (PAGE_W),
    .PAGE    (EXT_PAGE)
  ) u_map (
    .addr_i   (req_addr_i),
    .ext_i    (ext_mode_o),
    .global_i (gport_wr),
    .addr_o   (addr_m)
  );

  bcm_chan_sel #(.NUM_CH(NUM_CH)) u_sel (
    .sel_i (req_chan_i),
    .all_i (gport_wr),
    .en_o  (en_m)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_valid_o <= 1'b0;
      map_write_o <= 1'b0;
      map_addr_o  <= '0;
      map_data_o  <= '0;
      chan_en_o   <= '0;
      global_o    <= 1'b0;
      sync_stb_o  <= 1'b0;
      sync_idx_o  <= '0;
    end else begin
      map_valid_o <= req_valid_i;
      chan_en_o   <= req_valid_i ? en_m : '0;
      global_o    <= gcmd;
      sync_stb_o  <= gcmd && (cmd == CMD_SYNC);
      if (req_valid_i) begin
        map_write_o <= req_write_i;
        map_addr_o  <= addr_m;
        map_data_o  <= req_data_i;
        sync_idx_o  <= idx;
      end
    end
  end
endmodule

// File: rtl/bcm_chk.sv
module bcm_chk
  import bcm_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               map_valid_o,
  input logic               map_write_o,
  input logic [INT_AW-1:0]  map_addr_o,
  input logic [DW-1:0]      map_data_o,
  input logic [NUM_CH-1:0]  chan_en_o,
  input logic               global_o,
  input logic               ext_mode_o,
  input logic               sync_stb_o,
  input logic [3:0]         sync_idx_o
);
  // R1
  global_bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_valid_o && global_o |-> (&chan_en_o) && map_addr_o == INT_AW'(GLOBAL_ADDR));
  // R2
  ext_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_valid_o && global_o && map_data_o == CMD_EXT_ON |-> ext_mode_o);
  // R3
  ext_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_valid_o && global_o && map_data_o == CMD_EXT_OFF |-> !ext_mode_o);
  // R6
  onehot_chan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_valid_o && !global_o |-> $countones(chan_en_o) == 1);
  // R7
  sync_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_stb_o |-> map_valid_o && global_o && map_data_o[DW-1:DW-4] == SYNC_GRP
                   && sync_idx_o == map_data_o[3:0]);
  // R9
  other_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_valid_o && global_o && map_data_o != CMD_EXT_ON && map_data_o != CMD_EXT_OFF
    && map_data_o[DW-1:DW-4] != SYNC_GRP |-> !sync_stb_o && ext_mode_o == $past(ext_mode_o));
  // R10
  read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_valid_o && !map_write_o |-> !sync_stb_o && !global_o && ext_mode_o == $past(ext_mode_o));
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_valid_o |-> chan_en_o == '0 && !sync_stb_o && !global_o);
endmodule

bind bcast_cmd_mapper bcm_chk u_chk (.*);

// File: tb/sim_bcast_cmd_mapper.sv
`timescale 1ns/1ps
module sim_bcast_cmd_mapper;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_write_i = 1'b0;
  logic [4:0] req_addr_i = '0;
  logic [1:0] req_chan_i = '0;
  logic [7:0] req_data_i = '0;
  logic       map_valid_o, map_write_o, global_o, ext_mode_o, sync_stb_o;
  logic [7:0] map_addr_o, map_data_o;
  logic [3:0] chan_en_o, sync_idx_o;

  typedef struct {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] data;
    logic [3:0] en;
    logic       glb;
    logic       ext;
    logic       stb;
    logic [3:0] idx;
    int         rq;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  logic m_ext = 1'b0;
  logic done = 1'b0;

  always #4 clk_i = ~clk_i;

  bcast_cmd_mapper u0 (.*);

  task automatic txn(input logic wr, input logic [4:0] a, input logic [1:0] ch,
                     input logic [7:0] d, input int rq);
    exp_t e;
    logic gw;
    gw = wr && (a == 5'h1F);
    e.wr   = wr;
    e.data = d;
    e.glb  = gw;
    e.addr = gw ? 8'h1F : (m_ext ? {4'h2, a[3:0]} : {3'b000, a});
    e.en   = gw ? 4'hF : (4'b0001 << ch);
    e.stb  = gw && (d[7:4] == 4'hE);
    e.idx  = d[3:0];
    if (gw && d == 8'hCE) m_ext = 1'b1;
    else if (gw && d == 8'hCD) m_ext = 1'b0;
    e.ext  = m_ext;
    e.rq   = rq;
    exp_q.push_back(e);
    req_valid_i = 1'b1;
    req_write_i = wr;
    req_addr_i  = a;
    req_chan_i  = ch;
    req_data_i  = d;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (map_valid_o) begin
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R11 unexpected output act=%h exp=none", map_addr_o);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (map_write_o !== e.wr || map_addr_o !== e.addr || map_data_o !== e.data ||
              chan_en_o !== e.en || global_o !== e.glb || ext_mode_o !== e.ext ||
              sync_stb_o !== e.stb || (e.stb && sync_idx_o !== e.idx)) begin
            failures++;
            $display("FAIL R%0d act w=%b a=%h d=%h en=%b g=%b x=%b s=%b i=%h exp w=%b a=%h d=%h en=%b g=%b x=%b s=%b i=%h",
                     e.rq, map_write_o, map_addr_o, map_data_o, chan_en_o, global_o, ext_mode_o,
                     sync_stb_o, sync_idx_o, e.wr, e.addr, e.data, e.en, e.glb, e.ext, e.stb, e.idx);
          end
        end
      end else if (chan_en_o !== 4'h0 || sync_stb_o !== 1'b0 || ext_mode_o !== m_ext) begin
        // R11 idle outputs quiet, R7 strobe single cycle
        failures++;
        $display("FAIL R11 idle act en=%b s=%b x=%b exp en=0000 s=0 x=%b",
                 chan_en_o, sync_stb_o, ext_mode_o, m_ext);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R3 reset state
    checks++;
    if (ext_mode_o !== 1'b0 || map_valid_o !== 1'b0 || chan_en_o !== 4'h0) begin
      failures++;
      $display("FAIL R3 reset act x=%b v=%b en=%b exp x=0 v=0 en=0000",
               ext_mode_o, map_valid_o, chan_en_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    txn(1'b1, 5'h05, 2'd2, 8'hA1, 4);   // R4 R6 normal write
    txn(1'b0, 5'h13, 2'd1, 8'h00, 4);   // R4 normal read, bit 4 kept
    txn(1'b1, 5'h1F, 2'd0, 8'h55, 9);   // R9 R1 unknown global
    txn(1'b1, 5'h1F, 2'd3, 8'hE3, 7);   // R7 sync idx 3
    @(negedge clk_i);
    txn(1'b1, 5'h1F, 2'd1, 8'hEF, 7);   // R7 upper end
    txn(1'b1, 5'h1F, 2'd2, 8'hE0, 7);   // R7 lower end, back to back
    txn(1'b1, 5'h1F, 2'd0, 8'hDF, 9);   // R9 near sync group
    txn(1'b1, 5'h1F, 2'd1, 8'hCE, 2);   // R2 set page mode
    txn(1'b1, 5'h00, 2'd3, 8'h11, 5);   // R5 0x00 -> 0x20
    txn(1'b1, 5'h15, 2'd0, 8'h22, 5);   // R5 bit 4 ignored -> 0x25
    txn(1'b0, 5'h05, 2'd2, 8'h00, 6);   // R6 page mode read
    txn(1'b0, 5'h1F, 2'd2, 8'hCD, 10);  // R10 read of 0x1F with CD on bus
    txn(1'b1, 5'h1F, 2'd3, 8'h12, 9);   // R9 unknown in page mode
    txn(1'b1, 5'h1F, 2'd0, 8'hE7, 8);   // R8 global still decoded
    txn(1'b1, 5'h1F, 2'd1, 8'hCE, 2);   // R2 repeated set stays
    txn(1'b1, 5'h0F, 2'd2, 8'hCD, 8);   // R8 0x0F is not the port
    txn(1'b1, 5'h1F, 2'd2, 8'hCD, 8);   // R8 leave page mode
    txn(1'b1, 5'h15, 2'd1, 8'h33, 4);   // R4 back to normal
    txn(1'b1, 5'h1F, 2'd0, 8'hCD, 3);   // R3 clear while clear
    txn(1'b0, 5'h1F, 2'd3, 8'hCE, 10);  // R10 read never sets
    txn(1'b1, 5'h0A, 2'd1, 8'h44, 11);  // R11 data pass-through
    repeat (3) @(negedge clk_i);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R11 missing outputs act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL R11 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule